// File: doc/BRIEF.md
# Proportional-Integral Loop Filter for a Phase-Locked Loop

This block is the fixed-point loop filter that sits between the phase detector and the numerically controlled oscillator of a digital second-order phase-locked loop. Each accepted error sample is scaled by two gains that the surrounding logic can change at run time. A proportional gain acts on the present sample. An integral gain feeds a saturating accumulator. The sum of the two scaled terms, clipped to the output width, becomes the oscillator control word. The filter has a first-order denominator. The oscillator acts as the second integrator of the loop.

Two structural forms are offered. In the lagged form the integral contribution to the present output covers samples up to the previous one only. In the direct form the present sample enters the integral term at once. The form is captured while reset is held, so one run never mixes the two difference equations.

Error samples arrive on a valid/ready stream and control words leave on another. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is presented one clock later with `out_valid` high. It stays presented, unchanged, until `out_ready` is seen high. While a result waits with `out_ready` low, `in_ready` is low and the filter state is frozen. Gains and form select are plain control pins.

Top module: `pi_loop_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and the output register clear to zero and `out_valid` goes low. After reset, `out_ctrl` reads 0 and the first sample sees an integral term of 0.
- R2: The proportional term is floor(kp*x / 2^FRAC), where kp, x and the result are two's-complement.
- R3: With form 0 (lagged), y(n) = sat(P(n) + A(n-1)) and then A(n) = satA(A(n-1) + I(n)). Here I(n) = floor(ki*x(n) / 2^FRAC).
- R4: With form 1 (direct), A(n) = satA(A(n-1) + I(n)) and y(n) = sat(P(n) + A(n)).
- R5: State and `out_ctrl` change only on an accepted sample. A changing `in_err` with `in_valid` low has no effect.
- R6: `out_valid` is high in the cycle after an accepted sample. It stays high with `out_ctrl` stable until a clock edge where `out_ready` is high and no new sample is accepted.
- R7: `in_ready` equals `!out_valid || out_ready`. A sample offered while `in_ready` is low is not accepted and does not enter the accumulator.
- R8: The accumulator is AW bits wide. It clamps at 2^(AW-1)-1 and -2^(AW-1) instead of wrapping, so later samples of the opposite sign count down from the clamp value.
- R9: `out_ctrl` clamps to 2^(OW-1)-1 and -2^(OW-1) when P plus the integral term exceeds the OW-bit signed range.
- R10: `form_sel` is sampled only while `rst` is high. A change of `form_sel` after reset has no effect until the next reset.
- R11: `kp` and `ki` are read on the edge that accepts each sample, so a gain change applies from the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures `form_sel` |
| form_sel | input | 1 | 0 = lagged integral form, 1 = direct integral form |
| kp | input | GW | Signed proportional gain, FRAC fractional bits |
| ki | input | GW | Signed integral gain, FRAC fractional bits |
| in_valid | input | 1 | Error sample offered |
| in_ready | output | 1 | Filter can accept a sample |
| in_err | input | XW | Signed phase error sample |
| out_valid | output | 1 | Control word presented |
| out_ready | input | 1 | Downstream takes the control word |
| out_ctrl | output | OW | Signed oscillator control word |

## Verification
The hardest condition to reach from the ports is a clamped accumulator. It needs some thirty-odd full-scale samples at maximum integral gain before the clamp engages. Only a later run of opposite-sign samples shows whether the accumulator held at its limit or wrapped, because the output clamp hides the accumulator long before that. The bench drives that ramp with the proportional gain at zero and then reverses the error sign. It compares every output with a reference model until the value falls back inside the output range. A stall with a new sample held against low `in_ready` is driven separately. The sample that was refused must be absent from later results.

// File: rtl/pi_lf_pkg.sv
package pi_lf_pkg;
  typedef enum logic {
    FORM_LAGGED = 1'b0,
    FORM_DIRECT = 1'b1
  } lf_form_e;
endpackage

// File: rtl/pi_lf_sat.sv
// Clamp a signed value to a narrower signed width.
module pi_lf_sat #(
  parameter int IW = 25,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam int HW = IW - OW + 1;
  localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

  logic [HW-1:0] hi;
  logic          fits;

  assign hi   = din[IW-1:OW-1];
  assign fits = (hi == '0) || (hi == '1);

  always_comb begin
    if (fits)             dout = din[OW-1:0];
    else if (din[IW-1])   dout = MINV;
    else                  dout = MAXV;
  end
endmodule

// File: rtl/pi_lf_scale.sv
// Signed gain multiply with floor division by 2^FRAC.
module pi_lf_scale #(
  parameter int XW   = 12,
  parameter int GW   = 16,
  parameter int FRAC = 8
) (
  input  logic signed [XW-1:0]         x,
  input  logic signed [GW-1:0]         g,
  output logic signed [XW+GW-FRAC-1:0] y
);
  localparam int PW = XW + GW;
  logic signed [PW-1:0] prod;

  assign prod = PW'(x) * PW'(g);
  assign y    = prod[PW-1:FRAC];
endmodule

// File: rtl/pi_lf_integ.sv
// Saturating integral accumulator.
module pi_lf_integ #(
  parameter int IW = 20,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [IW-1:0] inc,
  output logic signed [AW-1:0] acc,
  output logic signed [AW-1:0] acc_next
);
  localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

  logic signed [AW:0] sum;

  assign sum = (AW+1)'(inc) + (AW+1)'(acc);

  pi_lf_sat #(.IW(AW+1), .OW(AW)) u_acc_sat (
    .din  (sum),
    .dout (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= acc_next;
  end

  // R5: no accepted sample, no accumulator change
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));
  // R8: clamp holds at the top against non-negative increments
  p_acc_top_r8: assert property (@(posedge clk) disable iff (rst)
    (en && acc == AMAX && !inc[IW-1]) |=> acc == AMAX);
  // R8: clamp holds at the bottom against negative increments
  p_acc_bot_r8: assert property (@(posedge clk) disable iff (rst)
    (en && acc == AMIN && inc[IW-1]) |=> acc == AMIN);
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import pi_lf_pkg::*;
#(
  parameter int XW   = 12,
  parameter int GW   = 16,
  parameter int FRAC = 8,
  parameter int AW   = 24,
  parameter int OW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 form_sel,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [XW-1:0] in_err,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_ctrl
);
  localparam int SW = XW + GW - FRAC;
  localparam int TW = ((SW > AW) ? SW : AW) + 1;

  lf_form_e            form_q;
  logic                in_fire;
  logic signed [SW-1:0] p_term;
  logic signed [SW-1:0] i_inc;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_nx;
  logic signed [AW-1:0] integ;
  logic signed [TW-1:0] total;
  logic signed [OW-1:0] y_sat;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) form_q <= lf_form_e'(form_sel);
  end

  pi_lf_scale #(.XW(XW), .GW(GW), .FRAC(FRAC)) u_prop (
    .x (in_err), .g (kp), .y (p_term)
  );

  pi_lf_scale #(.XW(XW), .GW(GW), .FRAC(FRAC)) u_intg (
    .x (in_err), .g (ki), .y (i_inc)
  );

  pi_lf_integ #(.IW(SW), .AW(AW)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .en       (in_fire),
    .inc      (i_inc),
    .acc      (acc_q),
    .acc_next (acc_nx)
  );

  generate
    if (AW >= SW) begin : g_width_ok
      always_comb integ = (form_q == FORM_DIRECT) ? acc_nx : acc_q;
    end else begin : g_width_bad
      initial $error("accumulator narrower than scaled product");
      always_comb integ = acc_q;
    end
  endgenerate

  assign total = TW'(p_term) + TW'(integ);

  pi_lf_sat #(.IW(TW), .OW(OW)) u_out_sat (
    .din  (total),
    .dout (y_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ctrl  <= '0;
      out_valid <= 1'b0;
    end else if (in_fire) begin
      out_ctrl  <= y_sat;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: an accepted sample is presented on the next cycle
  p_present_r6: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> out_valid);
  // R6: a waiting word is held until taken
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ctrl)));
  // R7: a stalled output blocks acceptance
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R10: form captured in reset stays fixed
  p_form_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(form_q));
endmodule

// File: tb/pi_loop_filter_bench.sv
module pi_loop_filter_bench;
  localparam int XW = 12, GW = 16, FRAC = 8, AW = 24, OW = 16;

  logic clk = 0;
  logic rst = 1;
  logic form_sel = 0;
  logic signed [GW-1:0] kp = 0, ki = 0;
  logic in_valid = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic signed [XW-1:0] in_err = 0;
  logic signed [OW-1:0] out_ctrl;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  longint m_acc = 0;
  bit m_direct = 0;

  always #4 clk = ~clk;

  pi_loop_filter #(.XW(XW), .GW(GW), .FRAC(FRAC), .AW(AW), .OW(OW)) u_pi_loop_filter (
    .clk(clk), .rst(rst), .form_sel(form_sel), .kp(kp), .ki(ki),
    .in_valid(in_valid), .in_ready(in_ready), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl)
  );

  localparam int NV = 8;
  localparam int VX [NV] = '{100, -50, 300, 0, -700, 2047, -2048, -1};
  localparam int VKP[NV] = '{256, 256, 512, 128, 1000, 300, 50, 1};
  localparam int VKI[NV] = '{64, 64, 32, 128, -200, 10, 500, 1};

  function automatic longint sat(longint v, int w);
    longint mx = (64'sd1 <<< (w - 1)) - 1;
    longint mn = -(64'sd1 <<< (w - 1));
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic longint fdiv(longint v);
    return v >>> FRAC;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit f);
    @(negedge clk);
    form_sel = f;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    m_acc = 0;
    m_direct = f;
  endtask

  // model of one accepted sample, per R2/R3/R4/R8/R9
  function automatic longint model(int x, int g_p, int g_i);
    longint p = fdiv(longint'(x) * g_p);
    longint inc = fdiv(longint'(x) * g_i);
    longint y;
    if (m_direct) begin
      m_acc = sat(m_acc + inc, AW);
      y = sat(p + m_acc, OW);
    end else begin
      y = sat(p + m_acc, OW);
      m_acc = sat(m_acc + inc, AW);
    end
    return y;
  endfunction

  task automatic send(int x, int g_p, int g_i, string tag);
    longint e;
    @(negedge clk);
    in_err = x; kp = g_p; ki = g_i; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    e = model(x, g_p, g_i);
    chk({tag, " valid R6"}, out_valid, 1);
    chk(tag, out_ctrl, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    longint y0;
    // R1 reset state
    do_reset(0);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_ctrl after reset", out_ctrl, 0);
    chk("R7 in_ready after reset", in_ready, 1);

    // table walk, lagged form (R2, R3, R11)
    for (int i = 0; i < NV; i++) send(VX[i], VKP[i], VKI[i], "R3 lagged vector");
    // table walk, direct form (R2, R4, R11)
    do_reset(1);
    for (int i = 0; i < NV; i++) send(VX[i], VKP[i], VKI[i], "R4 direct vector");

    // R2 floor of negative fraction, direct form, ki=0
    do_reset(1);
    send(-1, 1, 0, "R2 floor negative");
    chk("R2 floor value", out_ctrl, -1);

    // R5 hold between samples
    @(negedge clk);
    y0 = out_ctrl;
    chk("R6 valid drops when taken", out_valid, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_err = 12'(i * 333);
    end
    chk("R5 out_ctrl held", out_ctrl, y0);
    chk("R5 out_valid low", out_valid, 0);
    send(10, 0, 256, "R5 state untouched by idle input");

    // R7 back-pressure: refused sample must not enter the accumulator
    do_reset(0);
    out_ready = 0;
    send(200, 256, 256, "R7 first under stall");
    y0 = out_ctrl;
    @(negedge clk);
    in_err = 999; kp = 256; ki = 256; in_valid = 1;
    repeat (3) @(negedge clk);
    chk("R7 in_ready low while stalled", in_ready, 0);
    chk("R6 out_valid held", out_valid, 1);
    chk("R6 out_ctrl held", out_ctrl, y0);
    in_valid = 0;
    @(negedge clk);
    out_ready = 1;
    @(negedge clk);
    chk("R6 out_valid cleared after take", out_valid, 0);
    send(0, 0, 0, "R7 refused sample absent");

    // R10 form change without reset has no effect
    do_reset(0);
    form_sel = 1;
    send(100, 0, 256, "R10 still lagged");
    send(100, 0, 256, "R10 still lagged second");
    do_reset(1);
    send(100, 0, 256, "R10 direct after reset");

    // R8/R9 accumulator and output clamp
    do_reset(1);
    for (int i = 0; i < 40; i++) send(2047, 0, 32767, "R9 positive ramp");
    chk("R9 output at max", out_ctrl, 32767);
    for (int i = 0; i < 32; i++) send(-2048, 0, 32767, "R8 descent from clamp");
    chk("R8 value after descent", out_ctrl, 255);
    send(-2048, 32767, 0, "R9 negative clamp");
    chk("R9 output at min", out_ctrl, -32768);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule